// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the word address for a four-beat burst access to a synchronous memory array. A burst begins when either of two active-low load strobes is sampled low while the select input is high. One strobe is meant for a processor, the other for a memory controller. On that edge the full external address is captured. After that, an active-low advance input steps the two low address bits through the burst order. The upper address bits keep the value captured at the load.

A mode input picks the order of the low bits. When it is high, the order is interleaved: the start value XOR the beat index. When it is low, the order is linear: the start value plus the beat index, modulo four. The mode input is meant to have an external pull-up, so interleaved is the default. The count wraps after the fourth beat and does not stop. When no strobe and no advance is present, the address holds, which gives wait states between beats. The address output and the burst-active flag are both registered.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next `addr_out` is 0 and `burst_active` is 0.
- R2: When `strobe_p_n` is low and `sel` is high at an edge, the next `addr_out` equals `addr_in`, `burst_active` becomes 1 and the beat index restarts at 0. The value of `adv_n` has no effect on that edge.
- R3: When `strobe_c_n` is low and `sel` is high at an edge, the address is loaded in the same way as in R2.
- R4: The low bits step only when `adv_n` is low, both strobes are high and `burst_active` is 1. Each step raises the beat index by one, modulo 4.
- R5: With `mode` high (1 = interleaved), after a step `addr_out[1:0]` equals the loaded start bits XOR the beat index.
- R6: With `mode` low (0 = linear), after a step `addr_out[1:0]` equals (start bits + beat index) mod 4.
- R7: The fourth step after a load returns `addr_out[1:0]` to the loaded start bits.
- R8: `addr_out[16:2]` does not change on any step.
- R9: When both strobes and `adv_n` are high, `addr_out` and `burst_active` hold their values.
- R10: When a strobe is low and `sel` is low, `addr_out` holds and `burst_active` clears. Later advances have no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 17 | External word address |
| strobe_p_n | input | 1 | Processor load strobe, active low |
| strobe_c_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel | input | 1 | Chip-enable-qualified select, active high |
| mode | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_out | output | 17 | Registered word address |
| burst_active | output | 1 | A burst is loaded and may be advanced |

## Verification
The load and the advance can fall in the same cycle. The bench provokes this by holding `adv_n` low on every strobe edge, with either strobe. The address that follows must be the raw external address at beat zero, never a stepped one. Each load is followed by advances that include held wait cycles, in both orders and from all four start values. A behavioural model compares the outputs on every clock, including the wrap back to the start value and a strobe given while `sel` is low.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl (
  input  logic strobe_p_n,
  input  logic strobe_c_n,
  input  logic adv_n,
  input  logic sel,
  input  logic active,
  output logic do_load,
  output logic do_step,
  output logic do_drop
);
  logic any_strobe;
  always_comb begin
    any_strobe = !strobe_p_n || !strobe_c_n;
    do_load    = any_strobe && sel;
    do_drop    = any_strobe && !sel;
    do_step    = !any_strobe && !adv_n && active;
  end
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_pkg::*;
(
  input  beat_t start,
  input  beat_t beat,
  input  logic  interleave,
  output beat_t low
);
  always_comb begin
    if (interleave) low = start ^ beat;
    else            low = start + beat;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic              sel,
  input  logic              mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);
  localparam int UP_W = ADDR_W - BEAT_W;

  beat_t start_q, beat_q, beat_nx, low_nx;
  logic  do_load, do_step, do_drop;

  burst_seq_ctrl u_ctrl (
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .adv_n      (adv_n),
    .sel        (sel),
    .active     (burst_active),
    .do_load    (do_load),
    .do_step    (do_step),
    .do_drop    (do_drop)
  );

  assign beat_nx = beat_q + beat_t'(1);

  burst_order u_order (
    .start      (start_q),
    .beat       (beat_nx),
    .interleave (mode),
    .low        (low_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out     <= '0;
      burst_active <= 1'b0;
      start_q      <= '0;
      beat_q       <= '0;
    end else if (do_load) begin
      addr_out     <= addr_in;
      burst_active <= 1'b1;
      start_q      <= addr_in[BEAT_W-1:0];
      beat_q       <= '0;
    end else if (do_drop) begin
      burst_active <= 1'b0;
    end else if (do_step) begin
      beat_q               <= beat_nx;
      addr_out[BEAT_W-1:0] <= low_nx;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && !burst_active));

  assert_load_p_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p_n && sel) |=> (addr_out == $past(addr_in) && burst_active));

  assert_load_c_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobe_c_n && sel) |=> (addr_out == $past(addr_in) && burst_active));

  assert_upper_held_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe_p_n && strobe_c_n) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe_p_n && strobe_c_n && adv_n) |=> ($stable(addr_out) && $stable(burst_active)));

  assert_deselect_R10: assert property (@(posedge clk) disable iff (rst)
    ((!strobe_p_n || !strobe_c_n) && !sel) |=> ($stable(addr_out) && !burst_active));

  assert_idle_no_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!burst_active && strobe_p_n && strobe_c_n) |=> $stable(addr_out));

  logic unused_up;
  assign unused_up = (UP_W > 0);
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [16:0] addr_in = '0;
  logic        strobe_p_n = 1, strobe_c_n = 1, adv_n = 1, sel = 1, mode = 1;
  logic [16:0] addr_out;
  logic        burst_active;

  int total = 0, bad = 0;
  string cur_req = "R1";

  int m_addr = 0, m_start = 0, m_beat = 0;
  bit m_act = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst(rst), .addr_in(addr_in), .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n), .adv_n(adv_n), .sel(sel), .mode(mode),
    .addr_out(addr_out), .burst_active(burst_active)
  );

  always @(posedge clk) begin
    int low;
    if (rst) begin
      m_addr = 0; m_act = 0; m_beat = 0; m_start = 0;
    end else if (!strobe_p_n || !strobe_c_n) begin
      if (sel) begin
        m_addr = addr_in; m_start = addr_in % 4; m_beat = 0; m_act = 1;
      end else m_act = 0;
    end else if (!adv_n && m_act) begin
      m_beat = (m_beat + 1) % 4;
      low = mode ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
      m_addr = (m_addr / 4) * 4 + low;
    end
  end

  task automatic cyc(input bit p, input bit c, input bit a, input bit s,
                     input logic [16:0] ai, input string req);
    strobe_p_n = p; strobe_c_n = c; adv_n = a; sel = s; addr_in = ai;
    cur_req = req;
    @(negedge clk);
    total++;
    if (addr_out !== 17'(m_addr) || burst_active !== m_act) begin
      bad++;
      $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
               cur_req, addr_out, burst_active, 17'(m_addr), m_act);
    end
  endtask

  initial begin
    #(PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 1, 1, 17'h0, "R1");
    rst = 0;
    cyc(1, 1, 0, 1, 17'h0, "R4");
    for (int md = 0; md < 2; md++) begin
      mode = md[0];
      for (int st = 0; st < 4; st++) begin
        logic [16:0] base;
        base = {15'(17'h2A5 + st * 13 + md * 7), 2'(st)};
        cyc(0, 1, 0, 1, base, "R2");
        cyc(1, 1, 0, 1, 17'h1FFFF, md ? "R5" : "R6");
        cyc(1, 1, 1, 1, 17'h0, "R9");
        cyc(1, 1, 0, 1, 17'h0, md ? "R5" : "R6");
        cyc(1, 1, 1, 1, 17'h0, "R9");
        cyc(1, 1, 0, 1, 17'h0, "R8");
        cyc(1, 1, 0, 1, 17'h0, "R7");
        cyc(1, 0, 0, 1, base ^ 17'h15554, "R3");
        cyc(1, 1, 0, 1, 17'h0, "R4");
        cyc(1, 1, 0, 1, 17'h0, md ? "R5" : "R6");
        cyc(0, 0, 0, 1, base, "R2");
      end
    end
    mode = 1;
    cyc(1, 1, 0, 1, 17'h0, "R4");
    cyc(0, 1, 0, 0, 17'h0ABC, "R10");
    cyc(1, 1, 0, 1, 17'h0, "R10");
    cyc(1, 0, 1, 0, 17'h1234, "R10");
    cyc(1, 1, 1, 1, 17'h0, "R9");
    rst = 1;
    cyc(1, 1, 1, 1, 17'h0, "R1");
    rst = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule